// File: doc/BRIEF.md
# Segmented DAC Switch-Control Front End

This block is the digital front end of a 16-bit segmented current-steering converter. A parallel 16-bit word enters on `data_in`. Two 8-bit byte latches hold it, and each latch has its own active-high enable. While an enable is high, its byte passes straight through to the decode logic in the same cycle. While the enable is low, the byte keeps the value it captured at the last clock edge on which the enable was high. Driving both enables high gives a fully transparent 16-bit path, so a new word can be loaded in a single cycle.

The held word is split into two parts. The top four bits form a segment index, and a thermometer decoder expands it into 15 equal-weight switch lines. The remaining 12 bits drive the binary-weighted switches directly. Because every thermometer line has the same weight, the output is monotonic through the major carry from 0x7FFF to 0x8000. The analog ladder, the current outputs and settling are outside this block.

The stream-handshake convention of this project does not apply here: the byte strobes act as plain level enables, and there is no back-pressure.

Top module: `dac_switch_front`

## Requirements
- R1: `data_in[15]` is word bit 1, the most significant bit, and `data_in[0]` is bit 16, the least significant bit. `hi_en` gates `data_in[15:8]` and `lo_en` gates `data_in[7:0]`.
- R2: While a byte's enable is high, that byte of the held word equals the matching bits of `data_in` in the same cycle, with no clock delay.
- R3: While a byte's enable is low, that byte holds the `data_in` value present at the last rising clock edge on which the enable was high. Changes on its data inputs have no effect on the outputs.
- R4: After an asynchronous active-low reset, both held bytes are zero. With both enables low, `therm_sw` and `bin_sw` are then all zero.
- R5: Let k be the held word's bits [15:12]. Line `therm_sw[i]` (i = 0..14) is 1 exactly when i < k. k = 0 gives no lines and k = 15 gives all 15 lines.
- R6: `bin_sw` equals bits [11:0] of the held word, with no recoding.
- R7: For every one of the 65536 codes, (number of ones in `therm_sw`) * 4096 + `bin_sw` equals the held word. This makes the switch sum monotonic across every code step, including 0x7FFF to 0x8000.
- R8: With `hi_en` and `lo_en` both high, a 16-bit code applied on `data_in` appears completely on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the byte hold registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_en | input | 1 | Upper byte enable, active high |
| lo_en | input | 1 | Lower byte enable, active high |
| data_in | input | 16 | Input word; bit 15 is the MSB |
| therm_sw | output | 15 | Unary segment switch controls |
| bin_sw | output | 12 | Binary-weighted switch controls |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 4-bit segment, which gives 15 thermometer lines and 12 binary lines. At this size the bench can afford an exhaustive sweep of all 65536 codes through the transparent path, and it checks the switch sum at every code, including the major carry. Random interleavings of the two enables and of the data, mixed with directed cases, exercise capture and hold for each byte separately.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

  // Number of unary lines produced from a segment index of the given width.
  function automatic int unsigned unary_lines(input int unsigned seg_bits);
    return (1 << seg_bits) - 1;
  endfunction

  // Weight of one unary line expressed in binary LSBs.
  function automatic int unsigned line_weight(input int unsigned bin_bits);
    return 1 << bin_bits;
  endfunction

endpackage

// File: rtl/dac_byte_latch.sv
module dac_byte_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (en) held <= d;
  end

  // Transparent while enabled, otherwise the stored byte.
  assign q = en ? d : held;

  // R3: two consecutive disabled cycles keep the output still.
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (q == $past(q)));

  // R3: on the cycle the enable drops, the output keeps the last passed data.
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !en) |-> (q == $past(d)));

endmodule

// File: rtl/dac_therm_decoder.sv
module dac_therm_decoder
  import dac_front_pkg::*;
#(
  parameter int unsigned SEG_W = 4,
  localparam int unsigned LINES = unary_lines(SEG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEG_W-1:0] seg,
  output logic [LINES-1:0] therm
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign therm[i] = (seg > SEG_W'(i));
  end

  // R5: the number of active lines equals the segment index.
  assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm) == int'(seg));

  // R5: active lines form one contiguous run starting at line 0.
  assert_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm + 1'b1) & therm) == '0);

endmodule

// File: rtl/dac_switch_front.sv
module dac_switch_front
  import dac_front_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEG_W  = 4,
  localparam int unsigned BYTE_W = DATA_W / 2,
  localparam int unsigned BIN_W  = DATA_W - SEG_W,
  localparam int unsigned LINES  = unary_lines(SEG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic [DATA_W-1:0] data_in,
  output logic [LINES-1:0]  therm_sw,
  output logic [BIN_W-1:0]  bin_sw
);

  logic [1:0]        en_vec;
  logic [DATA_W-1:0] word;

  assign en_vec = {hi_en, lo_en};

  // Byte 1 is the upper half (word bits 1..8), byte 0 the lower half.
  for (genvar b = 0; b < 2; b++) begin : g_byte
    dac_byte_latch #(.W(BYTE_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_vec[b]),
      .d     (data_in[b*BYTE_W +: BYTE_W]),
      .q     (word[b*BYTE_W +: BYTE_W])
    );
  end

  dac_therm_decoder #(.SEG_W(SEG_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .seg   (word[DATA_W-1 -: SEG_W]),
    .therm (therm_sw)
  );

  assign bin_sw = word[BIN_W-1:0];

  // R2: an enabled upper byte reaches the word in the same cycle.
  assert_hi_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |-> (word[DATA_W-1 -: BYTE_W] == data_in[DATA_W-1 -: BYTE_W]));

  // R8: with both enables high the outputs carry the input code directly.
  assert_full_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en && lo_en) |-> (bin_sw == data_in[BIN_W-1:0]));

  // R7: line count times line weight plus binary part rebuilds the word.
  assert_rebuild_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(therm_sw) * line_weight(BIN_W) + int'(bin_sw)) == int'(word));

endmodule

// File: tb/test_dac_switch_front.sv
`timescale 1ns/1ps
module test_dac_switch_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_en = 1'b0;
  logic        lo_en = 1'b0;
  logic [15:0] data_in = 16'h0000;
  logic [14:0] therm_sw;
  logic [11:0] bin_sw;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_hi = 8'h00;
  logic [7:0] m_lo = 8'h00;

  always #2.5 clk = ~clk;

  dac_switch_front i_dac_switch_front (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .lo_en(lo_en),
    .data_in(data_in), .therm_sw(therm_sw), .bin_sw(bin_sw)
  );

  function automatic logic [14:0] exp_therm(input logic [15:0] w);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = (i < int'(w[15:12]));
    return r;
  endfunction

  function automatic logic [15:0] exp_word();
    return {hi_en ? data_in[15:8] : m_hi, lo_en ? data_in[7:0] : m_lo};
  endfunction

  task automatic chk_word(input string req, input logic [15:0] w);
    n_vec++;
    if (therm_sw !== exp_therm(w) || bin_sw !== w[11:0]) begin
      n_bad++;
      $display("FAIL %s: actual therm=%h bin=%h expected therm=%h bin=%h",
               req, therm_sw, bin_sw, exp_therm(w), w[11:0]);
    end
  endtask

  task automatic chk_sum(input logic [15:0] code);
    int s;
    s = $countones(therm_sw) * 4096 + int'(bin_sw);
    n_vec++;
    if (s != int'(code)) begin
      n_bad++;
      $display("FAIL R7: actual sum=%0d expected=%0d", s, code);
    end
  endtask

  // Drive on the falling edge, check 1 ns later, update model at the rising edge.
  task automatic apply(input string req, input logic h, input logic l,
                       input logic [15:0] d);
    @(negedge clk);
    hi_en = h; lo_en = l; data_in = d;
    #1;
    chk_word(req, exp_word());
    @(posedge clk);
    if (hi_en) m_hi = data_in[15:8];
    if (lo_en) m_lo = data_in[7:0];
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9316));
    // R4: reset state with enables low, data toggling.
    @(negedge clk); data_in = 16'hFFFF; #1; chk_word("R4", 16'h0000);
    @(negedge clk); data_in = 16'hA5C3; #1; chk_word("R4", 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    apply("R4", 1'b0, 1'b0, 16'h5A5A);

    // R1: each enable only opens its own half of the word.
    apply("R1", 1'b1, 1'b0, 16'hC300);
    apply("R1", 1'b0, 1'b1, 16'h00E7);
    // R3: disabled halves ignore data toggles.
    apply("R3", 1'b0, 1'b0, 16'h0000);
    apply("R3", 1'b0, 1'b0, 16'hFFFF);
    chk_word("R3", 16'hC3E7);
    apply("R3", 1'b0, 1'b1, 16'h1234);
    chk_word("R3", 16'hC334);
    // R2: transparent upper half follows within the cycle.
    apply("R2", 1'b1, 1'b0, 16'h7F00);
    // R5: segment extremes.
    apply("R5", 1'b1, 1'b1, 16'h0000);
    apply("R5", 1'b1, 1'b1, 16'hF000);
    apply("R6", 1'b1, 1'b1, 16'h0ABC);
    // R7: major carry in both directions.
    apply("R7", 1'b1, 1'b1, 16'h7FFF); chk_sum(16'h7FFF);
    apply("R7", 1'b1, 1'b1, 16'h8000); chk_sum(16'h8000);
    apply("R7", 1'b1, 1'b1, 16'h7FFF); chk_sum(16'h7FFF);

    // R8 and R7: exhaustive sweep through the fully transparent path.
    for (int c = 0; c < 65536; c++) begin
      apply("R8", 1'b1, 1'b1, 16'(c));
      chk_sum(16'(c));
    end

    // R2/R3: random interleaving of enables and data.
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] e;
      e = 2'($urandom_range(3, 0));
      apply("R3", e[1], e[0], 16'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule